// File: doc/BRIEF.md
# DMA Channel Completion Interrupt Aggregator

This block keeps the end-of-transfer bookkeeping for a small group of DMA channels. Each channel holds a current byte counter that counts down by one on every beat strobe from the transfer engine. When a beat takes the counter from one to zero, the channel records a sticky end flag. It then either reloads the counter from its reload register or drops its own enable, as its control bits select.

Two kinds of active-low interrupt line come from the end flags. Each channel has a dedicated line, gated by that channel's interrupt mask. One common line pools every channel whose common mask is set. Software programs the block through a single-cycle register write port. It acknowledges an end by writing a one to the channel's bit in the clear register.

Top module: `dma_end_irq`

## Requirements
- R1: After reset all current counts are 0, all enables are 0, every per-channel interrupt line is high and the common line is high.
- R2: A write with `wr_en_i` high takes effect on the next clock edge. The address is {kind[1:0], channel[1:0]}. Kind 0 is the control register: bit0 enable, bit1 reload on end, bit2 clear enable on end, bit3 per-channel interrupt mask, bit4 common interrupt mask. Kind 1 is the reload count, kind 2 the current count and kind 3 the clear register, in which the channel field is ignored.
- R3: An enabled channel whose count is nonzero decrements its count by 1 on each cycle in which its beat bit is high. A channel that is disabled, or whose count is already 0, keeps its count.
- R4: A beat that takes an enabled channel's count from 1 to 0 is that channel's transfer end, and it sets the channel's sticky end flag.
- R5: Bit i of `ch_irq_no` is low exactly when channel i's end flag is set and its per-channel mask is 1.
- R6: `cmn_irq_no` is low exactly when at least one channel has its end flag set and its common mask at 1.
- R7: A write to kind 3 clears the end flag of every channel i whose data bit i is 1. Data bits that are 0 leave their flags unchanged.
- R8: If a transfer end and a clear for the same channel fall in the same cycle, the flag stays set.
- R9: At a transfer end with reload selected, the current count is loaded from the reload register, and the channel stays enabled.
- R10: At a transfer end without reload, and with clear-enable selected, the channel's enable drops to 0. With neither option selected the enable stays 1 and the count stays 0. Reload takes precedence over clear-enable.
- R11: Changing a mask moves the interrupt lines in the cycle the write lands, and does not change any pending end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address {kind, channel} |
| wr_data_i | input | 16 | Write data |
| beat_i | input | 4 | Per-channel beat strobe |
| ch_irq_no | output | 4 | Per-channel interrupt request, active low |
| cmn_irq_no | output | 1 | Pooled common interrupt request, active low |
| cur_cnt_o | output | 64 | Current counts, channel i at bits [16i+15:16i] |
| ch_en_o | output | 4 | Channel enables |

## Verification
Every result of this block is due one clock edge after its stimulus. A register write, a beat and the resulting transfer end all update state at the edge that samples them, and the interrupt lines follow combinationally from the registered flags and masks, with no input-to-output path. The driver applies each stimulus at a falling edge and waits for the rising edge. Only then does it queue the expected count, enable or interrupt values. The monitor pops the queue shortly after that same rising edge, so each comparison is made in the exact cycle the requirement names, before the next stimulus can alter it.

// File: rtl/dma_end_pkg.sv
package dma_end_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_CLEAR  = 2'd3
  } reg_kind_e;

  // bit0 en .. bit4 cmn_en
  typedef struct packed {
    logic cmn_en;
    logic irq_en;
    logic end_clr;
    logic reload_en;
    logic en;
  } ch_ctrl_t;

  localparam int unsigned CTRL_W = $bits(ch_ctrl_t);

endpackage

// File: rtl/dma_end_chan.sv
module dma_end_chan
  import dma_end_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             rld_we_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             clr_i,
  input  logic             beat_i,
  output ch_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             flag_o,
  output logic             end_o
);

  ch_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;
  logic             flag_q;
  logic             step;
  logic             end_evt;

  assign step    = ctrl_q.en && beat_i && (cnt_q != '0);
  assign end_evt = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ch_ctrl_t'(wdata_i[CTRL_W-1:0]);
      // end action overrides a same-cycle software enable
      if (end_evt && !ctrl_q.reload_en && ctrl_q.end_clr) ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (end_evt) begin
      cnt_q <= ctrl_q.reload_en ? rld_q : '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rld_q <= '0;
    else if (rld_we_i)  rld_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (end_evt)  flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign flag_o = flag_q;
  assign end_o  = end_evt;

endmodule

// File: rtl/dma_end_irq_merge.sv
module dma_end_irq_merge #(
  parameter int unsigned NCH = 4
) (
  input  logic [NCH-1:0] flag_i,
  input  logic [NCH-1:0] irq_en_i,
  input  logic [NCH-1:0] cmn_en_i,
  output logic [NCH-1:0] ch_irq_no,
  output logic           cmn_irq_no
);

  logic [NCH-1:0] cmn_req;

  for (genvar i = 0; i < NCH; i++) begin : g_line
    assign ch_irq_no[i] = ~(flag_i[i] & irq_en_i[i]);
    assign cmn_req[i]   = flag_i[i] & cmn_en_i[i];
  end

  assign cmn_irq_no = ~|cmn_req;

endmodule

// File: rtl/dma_end_irq.sv
module dma_end_irq
  import dma_end_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned ADDR_W = CH_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic [NCH-1:0]       beat_i,
  output logic [NCH-1:0]       ch_irq_no,
  output logic                 cmn_irq_no,
  output logic [NCH*CNT_W-1:0] cur_cnt_o,
  output logic [NCH-1:0]       ch_en_o
);

  reg_kind_e        kind;
  logic [CH_W-1:0]  ch_sel;
  logic [NCH-1:0]   clr_vec;
  logic [NCH-1:0]   end_vec;
  logic [NCH-1:0]   flag_vec;
  logic [NCH-1:0]   irq_en_vec;
  logic [NCH-1:0]   cmn_en_vec;
  logic [NCH-1:0]   rld_en_vec;
  logic [NCH-1:0]   end_clr_vec;
  logic [NCH-1:0]   cnt_wr_vec;
  logic [NCH*CNT_W-1:0] rld_flat;

  assign kind    = reg_kind_e'(wr_addr_i[ADDR_W-1 -: 2]);
  assign ch_sel  = wr_addr_i[CH_W-1:0];
  assign clr_vec = (wr_en_i && kind == REG_CLEAR) ? wr_data_i[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic     hit;
    ch_ctrl_t ctrl;

    assign hit           = wr_en_i && (ch_sel == CH_W'(i));
    assign cnt_wr_vec[i] = hit && kind == REG_COUNT;

    dma_end_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctrl_we_i(hit && kind == REG_CTRL),
      .rld_we_i (hit && kind == REG_RELOAD),
      .cnt_we_i (cnt_wr_vec[i]),
      .wdata_i  (wr_data_i),
      .clr_i    (clr_vec[i]),
      .beat_i   (beat_i[i]),
      .ctrl_o   (ctrl),
      .cnt_o    (cur_cnt_o[i*CNT_W +: CNT_W]),
      .rld_o    (rld_flat[i*CNT_W +: CNT_W]),
      .flag_o   (flag_vec[i]),
      .end_o    (end_vec[i])
    );

    assign ch_en_o[i]     = ctrl.en;
    assign irq_en_vec[i]  = ctrl.irq_en;
    assign cmn_en_vec[i]  = ctrl.cmn_en;
    assign rld_en_vec[i]  = ctrl.reload_en;
    assign end_clr_vec[i] = ctrl.end_clr;
  end

  dma_end_irq_merge #(.NCH(NCH)) u_merge (
    .flag_i    (flag_vec),
    .irq_en_i  (irq_en_vec),
    .cmn_en_i  (cmn_en_vec),
    .ch_irq_no (ch_irq_no),
    .cmn_irq_no(cmn_irq_no)
  );

endmodule

// File: rtl/dma_end_irq_chk.sv
module dma_end_irq_chk #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NCH-1:0]       beat_i,
  input logic [NCH-1:0]       clr_vec,
  input logic [NCH-1:0]       end_vec,
  input logic [NCH-1:0]       flag_vec,
  input logic [NCH-1:0]       irq_en_vec,
  input logic [NCH-1:0]       cmn_en_vec,
  input logic [NCH-1:0]       rld_en_vec,
  input logic [NCH-1:0]       end_clr_vec,
  input logic [NCH-1:0]       cnt_wr_vec,
  input logic [NCH-1:0]       ch_en_o,
  input logic [NCH*CNT_W-1:0] cur_cnt_o,
  input logic [NCH*CNT_W-1:0] rld_flat,
  input logic [NCH-1:0]       ch_irq_no,
  input logic                 cmn_irq_no
);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_en_o[i] && beat_i[i] && cur_cnt_o[i*CNT_W +: CNT_W] > CNT_W'(1) && !cnt_wr_vec[i]
      |=> cur_cnt_o[i*CNT_W +: CNT_W] == CNT_W'($past(cur_cnt_o[i*CNT_W +: CNT_W]) - 1));

    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !beat_i[i] && !cnt_wr_vec[i] |=> $stable(cur_cnt_o[i*CNT_W +: CNT_W]));

    assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_vec[i] |=> flag_vec[i]);

    assert_ch_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_irq_no[i] == !(flag_vec[i] && irq_en_vec[i]));

    assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_vec[i] && !clr_vec[i] |=> flag_vec[i]);

    assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_vec[i] && !end_vec[i] |=> !flag_vec[i]);

    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_vec[i] && clr_vec[i] |=> flag_vec[i]);

    assert_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_vec[i] && rld_en_vec[i]
      |=> cur_cnt_o[i*CNT_W +: CNT_W] == $past(rld_flat[i*CNT_W +: CNT_W]));

    assert_end_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_vec[i] && !rld_en_vec[i] && end_clr_vec[i] |=> !ch_en_o[i]);
  end

  assert_cmn_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmn_irq_no == ((flag_vec & cmn_en_vec) == '0));

endmodule

bind dma_end_irq dma_end_irq_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .beat_i     (beat_i),
  .clr_vec    (clr_vec),
  .end_vec    (end_vec),
  .flag_vec   (flag_vec),
  .irq_en_vec (irq_en_vec),
  .cmn_en_vec (cmn_en_vec),
  .rld_en_vec (rld_en_vec),
  .end_clr_vec(end_clr_vec),
  .cnt_wr_vec (cnt_wr_vec),
  .ch_en_o    (ch_en_o),
  .cur_cnt_o  (cur_cnt_o),
  .rld_flat   (rld_flat),
  .ch_irq_no  (ch_irq_no),
  .cmn_irq_no (cmn_irq_no)
);

// File: tb/dma_end_irq_bench.sv
module dma_end_irq_bench;

  localparam int NCH   = 4;
  localparam int CNT_W = 16;

  // results: 0..3 count of channel, 4 enables, 5 channel lines, 6 common line
  localparam int SEL_EN  = 4;
  localparam int SEL_IRQ = 5;
  localparam int SEL_CMN = 6;

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] val;
  } item_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wr_en = 1'b0;
  logic [3:0]           wr_addr = '0;
  logic [15:0]          wr_data = '0;
  logic [NCH-1:0]       beat = '0;
  logic [NCH-1:0]       ch_irq_n;
  logic                 cmn_irq_n;
  logic [NCH*CNT_W-1:0] cur_cnt;
  logic [NCH-1:0]       ch_en;

  item_t q[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  dma_end_irq #(.NCH(NCH), .CNT_W(CNT_W)) u_dma_end_irq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .beat_i    (beat),
    .ch_irq_no (ch_irq_n),
    .cmn_irq_no(cmn_irq_n),
    .cur_cnt_o (cur_cnt),
    .ch_en_o   (ch_en)
  );

  function automatic logic [15:0] observe(int sel);
    case (sel)
      SEL_EN:  return {12'b0, ch_en};
      SEL_IRQ: return {12'b0, ch_irq_n};
      SEL_CMN: return {15'b0, cmn_irq_n};
      default: return cur_cnt[sel*CNT_W +: CNT_W];
    endcase
  endfunction

  // monitor: compares queued expectations just after the edge that produced them
  initial begin
    item_t it;
    logic [15:0] act;
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        it  = q.pop_front();
        act = observe(it.sel);
        total++;
        if (act !== it.val) begin
          bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
        end
      end
    end
  end

  task automatic cyc(input logic w, input logic [3:0] a, input logic [15:0] d,
                     input logic [3:0] b);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; beat = b;
    @(posedge clk);
  endtask

  task automatic expect_val(input string req, input int sel, input logic [15:0] v);
    q.push_back('{req, sel, v});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    expect_val("R1", 0, 0);
    expect_val("R1", 3, 0);
    expect_val("R1", SEL_EN, 0);
    expect_val("R1", SEL_IRQ, 16'hF);
    expect_val("R1", SEL_CMN, 1);

    // channel 0: count 3, enable + channel mask
    cyc(1, 4'd8, 16'd3, 0);
    expect_val("R2", 0, 3);
    cyc(1, 4'd0, 16'h09, 0);
    expect_val("R2", SEL_EN, 16'h1);
    cyc(0, 0, 0, 4'b0011);
    expect_val("R3", 0, 2);
    expect_val("R3", 1, 0);            // disabled channel ignores beat
    cyc(0, 0, 0, 4'b0001);
    expect_val("R3", 0, 1);
    expect_val("R5", SEL_IRQ, 16'hF);
    cyc(0, 0, 0, 4'b0001);
    expect_val("R4", 0, 0);
    expect_val("R5", SEL_IRQ, 16'hE);
    expect_val("R6", SEL_CMN, 1);      // common mask off
    expect_val("R10", SEL_EN, 16'h1);  // neither option: stays enabled
    cyc(0, 0, 0, 4'b0001);
    expect_val("R3", 0, 0);            // count 0 holds

    // mask changes keep pending flag
    cyc(1, 4'd0, 16'h19, 0);
    expect_val("R11", SEL_CMN, 0);
    expect_val("R11", SEL_IRQ, 16'hE);
    cyc(1, 4'd0, 16'h11, 0);
    expect_val("R11", SEL_IRQ, 16'hF);
    expect_val("R11", SEL_CMN, 0);
    cyc(1, 4'd0, 16'h19, 0);
    expect_val("R11", SEL_IRQ, 16'hE);

    // clear: zero bit has no effect, then one clears
    cyc(1, 4'd12, 16'h000E, 0);
    expect_val("R7", SEL_IRQ, 16'hE);
    expect_val("R7", SEL_CMN, 0);
    cyc(1, 4'd12, 16'h0001, 0);
    expect_val("R7", SEL_IRQ, 16'hF);
    expect_val("R7", SEL_CMN, 1);

    // channel 1: reload 2, reload + end_clr (reload wins) + channel mask
    cyc(1, 4'd5, 16'd2, 0);
    cyc(1, 4'd9, 16'd2, 0);
    cyc(1, 4'd1, 16'h0F, 0);
    expect_val("R2", SEL_EN, 16'h3);
    expect_val("R2", 1, 2);
    cyc(0, 0, 0, 4'b0010);
    expect_val("R3", 1, 1);
    cyc(0, 0, 0, 4'b0010);
    expect_val("R9", 1, 2);
    expect_val("R10", SEL_EN, 16'h3);
    expect_val("R5", SEL_IRQ, 16'hD);
    cyc(0, 0, 0, 4'b0010);
    expect_val("R9", 1, 1);
    cyc(1, 4'd12, 16'h0002, 4'b0010);  // end and clear together
    expect_val("R8", SEL_IRQ, 16'hD);
    expect_val("R9", 1, 2);
    cyc(1, 4'd12, 16'h0002, 0);
    expect_val("R7", SEL_IRQ, 16'hF);

    // channel 2: end clears enable, common mask only
    cyc(1, 4'd10, 16'd1, 0);
    cyc(1, 4'd2, 16'h15, 0);
    expect_val("R2", SEL_EN, 16'h7);
    cyc(0, 0, 0, 4'b0100);
    expect_val("R4", 2, 0);
    expect_val("R10", SEL_EN, 16'h3);
    expect_val("R6", SEL_CMN, 0);
    expect_val("R5", SEL_IRQ, 16'hF);

    // channel 3: both masks, common line pools channels 2 and 3
    cyc(1, 4'd11, 16'd1, 0);
    cyc(1, 4'd3, 16'h19, 0);
    cyc(0, 0, 0, 4'b1000);
    expect_val("R5", SEL_IRQ, 16'h7);
    expect_val("R6", SEL_CMN, 0);
    cyc(1, 4'd12, 16'h0004, 0);
    expect_val("R6", SEL_CMN, 0);
    cyc(1, 4'd12, 16'h0008, 0);
    expect_val("R6", SEL_CMN, 1);
    expect_val("R5", SEL_IRQ, 16'hF);

    // disabled channel with nonzero count ignores beats
    cyc(1, 4'd10, 16'd5, 0);
    cyc(0, 0, 0, 4'b0100);
    expect_val("R3", 2, 5);

    cyc(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule